// File: doc/BRIEF.md
# Write Completion Tracker

This block keeps one pending record for every write of a coalesced write group after the group has been issued downstream. Each record holds the group's sequence number, the byte address of the write and the identifier of the requester that sent it. Writes are entered one per cycle on an allocation handshake. Consecutive allocations that carry the same sequence number belong to one group and share one sequence slot.

The downstream cache later returns a completion callback made of a sequence number and a line address. The tracker selects every pending record that has that sequence number and whose address, with the offset inside the line dropped, equals the callback line. It answers each selected record on a response handshake that carries the requester identifier and the original address, and then deletes the record.

When the last record of a sequence number is gone, its slot is released so that a new sequence number can take it. After each callback has been fully handled, the tracker raises a one-cycle retry strobe so that stalled requesters can reissue. A callback whose sequence number has no pending records at all is flagged as a protocol error.

Top module: `wr_cmpl_tracker`

## Requirements
- R1: After synchronous reset no record or slot is held: allocReady and cbReady are 1, and rspValid, retryPulse and errPulse are 0.
- R2: An accepted allocation stores its sequence number, address and requester. When all DEPTH records are occupied, allocReady is 0.
- R3: When all SLOTS sequence slots hold other sequence numbers, allocReady is 0 for an unseen sequence number. It stays 1 for a sequence number that already owns a slot while records are free.
- R4: A callback selects exactly the pending records whose sequence number equals cbSeq and whose address bits [ADDR_W-1:log2(LINE_BYTES)] equal cbLine. Each selected record produces one response and is deleted. All other records are kept.
- R5: Responses go out one per cycle while rspReady is 1, lowest record index first. Each response carries the record's requester and full address, and both stay stable while rspValid is 1 and rspReady is 0.
- R6: From the cycle after a callback is accepted until the cycle after its last response, cbReady and allocReady are 0.
- R7: Exactly one cycle after the last response of a callback, or one cycle after acceptance if nothing matched, retryPulse is 1 for one cycle.
- R8: A callback whose sequence number has no pending record produces no response. It raises errPulse together with its retryPulse.
- R9: When the last record of a sequence number is deleted, that slot is released and an unseen sequence number can be allocated again.
- R10: Matching ignores the address bits below the line size. Records on the same line under a different sequence number are not touched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| allocValid | input | 1 | A write of an issued group is offered |
| allocReady | output | 1 | The write can be recorded |
| allocSeq | input | SEQ_W | Sequence number of the write's group |
| allocAddr | input | ADDR_W | Byte address of the write |
| allocReq | input | REQ_W | Requester identifier of the write |
| cbValid | input | 1 | A completion callback is offered |
| cbReady | output | 1 | The callback is taken |
| cbSeq | input | SEQ_W | Callback sequence number |
| cbLine | input | ADDR_W-log2(LINE_BYTES) | Callback line address |
| rspValid | output | 1 | A completion response is presented |
| rspReady | input | 1 | The requester side takes the response |
| rspReq | output | REQ_W | Requester that receives the response |
| rspAddr | output | ADDR_W | Address of the completed write |
| retryPulse | output | 1 | One-cycle strobe after a callback has been handled |
| errPulse | output | 1 | The callback named a sequence number with no records |

## Verification
Callbacks are tried against a mixed population of records. One line holds two writes of one group. The same line holds a write of another group. One group spreads over two lines. One callback names a line with nothing pending, and one names a sequence number that was never seen. Together these separate matching by both keys from matching by either key alone, show that the in-line offset is ignored, and show that an empty match differs from a protocol error. A full table of one group answered by a single callback checks multi-record retirement and response order. A four-group fill checks slot exhaustion and release. A stalled response checks hold-off and stability.

// File: rtl/wct_pkg.sv
package wct_pkg;
  typedef struct packed {
    logic alloc;
    logic capture;
    logic retire;
    logic freeSlot;
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RETIRE, ST_DONE} state_t;
endpackage

// File: rtl/wct_datapath.sv
module wct_datapath
  import wct_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int SLOTS      = 4,
  parameter int SEQ_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int REQ_W      = 4,
  parameter int LINE_BYTES = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  strobe_t                         strb,
  input  logic [SEQ_W-1:0]                allocSeq,
  input  logic [ADDR_W-1:0]               allocAddr,
  input  logic [REQ_W-1:0]                allocReq,
  input  logic [SEQ_W-1:0]                cbSeq,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] cbLine,
  output logic                            allocOk,
  output logic                            matchAny,
  output logic                            pendLast,
  output logic                            errFlag,
  output logic [REQ_W-1:0]                rspReq,
  output logic [ADDR_W-1:0]               rspAddr
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [DEPTH-1:0]  entValid;
  logic [SEQ_W-1:0]  entSeq  [DEPTH];
  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [REQ_W-1:0]  entReq  [DEPTH];
  logic [SLOTS-1:0]  slotValid;
  logic [SEQ_W-1:0]  slotSeq [SLOTS];
  logic [DEPTH-1:0]  pendMask;
  logic [SEQ_W-1:0]  curSeq;

  logic [IDX_W-1:0]  freeIdx, pickIdx;
  logic [SLOT_W-1:0] freeSlotIdx;
  logic              full, allocSeqHit, slotFreeAny, seqKnown, remainCurSeq;
  logic [DEPTH-1:0]  matchVec;

  always_comb begin
    freeIdx = '0;
    pickIdx = '0;
    freeSlotIdx = '0;
    allocSeqHit = 1'b0;
    slotFreeAny = 1'b0;
    seqKnown = 1'b0;
    remainCurSeq = 1'b0;
    full = &entValid;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!entValid[i]) freeIdx = IDX_W'(i);
      if (pendMask[i]) pickIdx = IDX_W'(i);
      matchVec[i] = entValid[i] && (entSeq[i] == cbSeq) &&
                    (entAddr[i][ADDR_W-1:OFF_W] == cbLine);
      if (entValid[i] && entSeq[i] == cbSeq) seqKnown = 1'b1;
      if (entValid[i] && entSeq[i] == curSeq) remainCurSeq = 1'b1;
    end
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!slotValid[s]) begin
        freeSlotIdx = SLOT_W'(s);
        slotFreeAny = 1'b1;
      end
      if (slotValid[s] && slotSeq[s] == allocSeq) allocSeqHit = 1'b1;
    end
  end

  assign allocOk  = !full && (allocSeqHit || slotFreeAny);
  assign matchAny = |matchVec;
  assign pendLast = ($countones(pendMask) == 1);
  assign rspReq   = entReq[pickIdx];
  assign rspAddr  = entAddr[pickIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      entValid  <= '0;
      slotValid <= '0;
      pendMask  <= '0;
      curSeq    <= '0;
      errFlag   <= 1'b0;
    end else begin
      if (strb.alloc) begin
        entValid[freeIdx] <= 1'b1;
        entSeq[freeIdx]   <= allocSeq;
        entAddr[freeIdx]  <= allocAddr;
        entReq[freeIdx]   <= allocReq;
        if (!allocSeqHit) begin
          slotValid[freeSlotIdx] <= 1'b1;
          slotSeq[freeSlotIdx]   <= allocSeq;
        end
      end
      if (strb.capture) begin
        pendMask <= matchVec;
        curSeq   <= cbSeq;
        errFlag  <= !seqKnown;
      end
      if (strb.retire) begin
        entValid[pickIdx] <= 1'b0;
        pendMask[pickIdx] <= 1'b0;
      end
      if (strb.freeSlot && !remainCurSeq) begin
        for (int s = 0; s < SLOTS; s++)
          if (slotValid[s] && slotSeq[s] == curSeq) slotValid[s] <= 1'b0;
      end
    end
  end

  // R2: the control never records into a full table
  a_r2_alloc_room: assert property (@(posedge clk) disable iff (rst)
    strb.alloc |-> !full);
  // R5: a response is only retired while a matched record is pending
  a_r5_retire_pending: assert property (@(posedge clk) disable iff (rst)
    strb.retire |-> (pendMask != '0) && entValid[pickIdx]);
  // R8: an unknown sequence number never leaves records to retire
  a_r8_err_no_match: assert property (@(posedge clk) disable iff (rst)
    (strb.freeSlot && errFlag) |-> (pendMask == '0));
  // R9: a released slot leaves no record of that sequence number behind
  a_r9_slot_release: assert property (@(posedge clk) disable iff (rst)
    (strb.freeSlot && !remainCurSeq) |=> !remainCurSeq);
endmodule

// File: rtl/wct_control.sv
module wct_control
  import wct_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    allocValid,
  input  logic    cbValid,
  input  logic    rspReady,
  input  logic    allocOk,
  input  logic    matchAny,
  input  logic    pendLast,
  input  logic    errFlag,
  output logic    allocReady,
  output logic    cbReady,
  output logic    rspValid,
  output logic    retryPulse,
  output logic    errPulse,
  output strobe_t strb
);
  state_t state, stateNext;
  logic   idle;

  assign idle       = (state == ST_IDLE);
  assign cbReady    = idle;
  assign allocReady = idle && !cbValid && allocOk;
  assign rspValid   = (state == ST_RETIRE);
  assign retryPulse = (state == ST_DONE);
  assign errPulse   = retryPulse && errFlag;

  always_comb begin
    strb.alloc    = allocValid && allocReady;
    strb.capture  = cbValid && idle;
    strb.retire   = rspValid && rspReady;
    strb.freeSlot = retryPulse;
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (strb.capture) stateNext = matchAny ? ST_RETIRE : ST_DONE;
      ST_RETIRE: if (strb.retire && pendLast) stateNext = ST_DONE;
      ST_DONE:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  // R7: retry follows the end of retirement by no gap
  a_r7_retry_after_rsp: assert property (@(posedge clk) disable iff (rst)
    $fell(rspValid) |-> retryPulse);
  // R6: no callback is taken while responses are still owed
  a_r6_hold_off: assert property (@(posedge clk) disable iff (rst)
    (rspValid || retryPulse) |-> !cbReady && !allocReady);
endmodule

// File: rtl/wr_cmpl_tracker.sv
module wr_cmpl_tracker
  import wct_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int SLOTS      = 4,
  parameter int SEQ_W      = 8,
  parameter int ADDR_W     = 16,
  parameter int REQ_W      = 4,
  parameter int LINE_BYTES = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 allocValid,
  output logic                                 allocReady,
  input  logic [SEQ_W-1:0]                     allocSeq,
  input  logic [ADDR_W-1:0]                    allocAddr,
  input  logic [REQ_W-1:0]                     allocReq,
  input  logic                                 cbValid,
  output logic                                 cbReady,
  input  logic [SEQ_W-1:0]                     cbSeq,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] cbLine,
  output logic                                 rspValid,
  input  logic                                 rspReady,
  output logic [REQ_W-1:0]                     rspReq,
  output logic [ADDR_W-1:0]                    rspAddr,
  output logic                                 retryPulse,
  output logic                                 errPulse
);
  strobe_t strb;
  logic    allocOk, matchAny, pendLast, errFlag;

  wct_datapath #(
    .DEPTH(DEPTH), .SLOTS(SLOTS), .SEQ_W(SEQ_W),
    .ADDR_W(ADDR_W), .REQ_W(REQ_W), .LINE_BYTES(LINE_BYTES)
  ) dp (
    .clk(clk), .rst(rst), .strb(strb),
    .allocSeq(allocSeq), .allocAddr(allocAddr), .allocReq(allocReq),
    .cbSeq(cbSeq), .cbLine(cbLine),
    .allocOk(allocOk), .matchAny(matchAny), .pendLast(pendLast),
    .errFlag(errFlag), .rspReq(rspReq), .rspAddr(rspAddr)
  );

  wct_control ctl (
    .clk(clk), .rst(rst),
    .allocValid(allocValid), .cbValid(cbValid), .rspReady(rspReady),
    .allocOk(allocOk), .matchAny(matchAny), .pendLast(pendLast),
    .errFlag(errFlag),
    .allocReady(allocReady), .cbReady(cbReady), .rspValid(rspValid),
    .retryPulse(retryPulse), .errPulse(errPulse), .strb(strb)
  );

  // R5: a stalled response keeps its contents
  a_r5_rsp_stable: assert property (@(posedge clk) disable iff (rst)
    (rspValid && !rspReady) |=> rspValid && $stable(rspReq) && $stable(rspAddr));
endmodule

// File: tb/wr_cmpl_tracker_test.sv
module wr_cmpl_tracker_test;
  localparam int SEQ_W = 8, ADDR_W = 16, REQ_W = 4, LINE_W = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic allocValid = 1'b0, cbValid = 1'b0, rspReady = 1'b1;
  logic allocReady, cbReady, rspValid, retryPulse, errPulse;
  logic [SEQ_W-1:0] allocSeq = '0, cbSeq = '0;
  logic [ADDR_W-1:0] allocAddr = '0, rspAddr;
  logic [REQ_W-1:0] allocReq = '0, rspReq;
  logic [LINE_W-1:0] cbLine = '0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wr_cmpl_tracker uut (
    .clk(clk), .rst(rst),
    .allocValid(allocValid), .allocReady(allocReady), .allocSeq(allocSeq),
    .allocAddr(allocAddr), .allocReq(allocReq),
    .cbValid(cbValid), .cbReady(cbReady), .cbSeq(cbSeq), .cbLine(cbLine),
    .rspValid(rspValid), .rspReady(rspReady), .rspReq(rspReq), .rspAddr(rspAddr),
    .retryPulse(retryPulse), .errPulse(errPulse)
  );

  typedef struct packed {
    logic [7:0]  seq;
    logic [11:0] line;
    logic [3:0]  cnt;
    logic [3:0]  first;
    logic [15:0] mask;
    logic        err;
  } cbRow_t;

  localparam int NROWS = 6;
  localparam cbRow_t ROWS [NROWS] = '{
    '{seq: 8'd5, line: 12'h010, cnt: 4'd2, first: 4'd1, mask: 16'h0006, err: 1'b0}, // R4 R10
    '{seq: 8'd7, line: 12'h030, cnt: 4'd1, first: 4'd5, mask: 16'h0020, err: 1'b0}, // R4
    '{seq: 8'd5, line: 12'h050, cnt: 4'd0, first: 4'd0, mask: 16'h0000, err: 1'b0}, // R7
    '{seq: 8'd9, line: 12'h010, cnt: 4'd0, first: 4'd0, mask: 16'h0000, err: 1'b1}, // R8
    '{seq: 8'd5, line: 12'h020, cnt: 4'd1, first: 4'd3, mask: 16'h0008, err: 1'b0}, // R9
    '{seq: 8'd7, line: 12'h010, cnt: 4'd1, first: 4'd4, mask: 16'h0010, err: 1'b0}  // R10
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doAlloc(input logic [7:0] s, input logic [15:0] a, input logic [3:0] r);
    @(negedge clk);
    allocSeq = s; allocAddr = a; allocReq = r; allocValid = 1'b1;
    #1;
    check(allocReady === 1'b1, "R2 alloc accepted", allocReady, 1);
    @(posedge clk);
    @(negedge clk);
    allocValid = 1'b0;
  endtask

  task automatic probe(input logic [7:0] s, input logic exp, input string tag);
    @(negedge clk);
    allocSeq = s; allocValid = 1'b0;
    #1;
    check(allocReady === exp, tag, allocReady, exp);
  endtask

  task automatic doCb(input cbRow_t row, input string tag);
    int cnt = 0;
    logic [15:0] mask = '0;
    logic [3:0] first = '0;
    bit sawRetry = 1'b0, lineOk = 1'b1;
    logic gotErr = 1'b0;
    @(negedge clk);
    cbSeq = row.seq; cbLine = row.line; cbValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cbValid = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (rspValid) begin
        if (cnt == 0) first = rspReq;
        mask[rspReq] = 1'b1;
        if (rspAddr[15:4] != row.line) lineOk = 1'b0;
        cnt++;
      end
      if (retryPulse) begin
        sawRetry = 1'b1;
        gotErr = errPulse;
        break;
      end
      @(negedge clk);
    end
    check(cnt == int'(row.cnt), {tag, " R4 response count"}, cnt, row.cnt);
    check(mask == row.mask, {tag, " R4 requesters answered"}, mask, row.mask);
    if (row.cnt != 0)
      check(first == row.first, {tag, " R5 lowest index first"}, first, row.first);
    check(lineOk, {tag, " R4 response line"}, lineOk, 1);
    check(sawRetry, {tag, " R7 retry pulse"}, sawRetry, 1);
    check(gotErr === row.err, {tag, " R8 error flag"}, gotErr, row.err);
    @(negedge clk);
    check(retryPulse === 1'b0 && cbReady === 1'b1, {tag, " R7 single pulse"}, retryPulse, 0);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(allocReady === 1 && cbReady === 1 && rspValid === 0 &&
          retryPulse === 0 && errPulse === 0, "R1 reset state",
          {allocReady, cbReady, rspValid, retryPulse, errPulse}, 5'b11000);

    // mixed population
    doAlloc(8'd5, 16'h0104, 4'd1);
    doAlloc(8'd5, 16'h0108, 4'd2);
    doAlloc(8'd5, 16'h0200, 4'd3);
    doAlloc(8'd7, 16'h0100, 4'd4);
    doAlloc(8'd7, 16'h0300, 4'd5);
    for (int i = 0; i < NROWS; i++) doCb(ROWS[i], $sformatf("row%0d", i));

    // full table of one group, answered by one callback
    for (int i = 0; i < 8; i++) doAlloc(8'd1, 16'h0400 + 16'(i * 2), 4'(i));
    probe(8'd1, 1'b0, "R2 full table blocks");
    doCb('{seq: 8'd1, line: 12'h040, cnt: 4'd8, first: 4'd0, mask: 16'h00ff, err: 1'b0}, "full");
    probe(8'd2, 1'b1, "R9 table and slot free again");

    // slot exhaustion
    for (int i = 0; i < 4; i++) doAlloc(8'd10 + 8'(i), 16'h0500 + 16'(i * 16'h10), 4'(i + 8));
    probe(8'd14, 1'b0, "R3 unseen sequence blocked");
    probe(8'd11, 1'b1, "R3 owned sequence accepted");

    // stalled response on seq 10
    rspReady = 1'b0;
    @(negedge clk);
    cbSeq = 8'd10; cbLine = 12'h050; cbValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cbValid = 1'b0;
    check(rspValid === 1 && rspReq === 4'd8 && rspAddr === 16'h0500,
          "R5 stalled response", {rspReq, rspAddr}, {4'd8, 16'h0500});
    check(cbReady === 0 && allocReady === 0, "R6 hold-off during retire",
          {cbReady, allocReady}, 2'b00);
    repeat (3) @(negedge clk);
    check(rspValid === 1 && rspReq === 4'd8 && rspAddr === 16'h0500,
          "R5 response held stable", {rspReq, rspAddr}, {4'd8, 16'h0500});
    rspReady = 1'b1;
    @(negedge clk);
    check(rspValid === 0 && retryPulse === 1 && cbReady === 0, "R7 retry after release",
          {rspValid, retryPulse, cbReady}, 3'b010);
    probe(8'd14, 1'b1, "R9 released slot reused");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule